// File: doc/BRIEF.md
# Single-Precision Compare, Min/Max and Saturate Unit

This block evaluates one operation at a time on single-precision floating-point bit patterns. A 4-bit operation code selects either a predicate (equal, not equal, less than, greater or equal) or a value operation (minimum, maximum, clamp to the unit interval, absolute value, negation, sign). Every decision is made with integer comparators and bit tests on the raw encodings. Nothing in the block normalises, rounds or does any arithmetic on the values.

Predicates appear on a 1-bit output, and value results appear on a 32-bit output. Whichever output the selected operation does not use is driven to zero. By default a single register stage holds both outputs, so a result appears one clock after its operands. Setting `OUT_REG` to 0 removes that stage and the unit becomes purely combinational.

Top module: `fpcm_unit`

## Requirements
- R1: Code 0 (equal) gives 1 when the two patterns are identical, or when both operands are zeros of either sign. It gives 0 whenever either operand is a NaN.
- R2: Code 1 (not equal) is the inverse of code 0. In particular it gives 1 whenever either operand is a NaN.
- R3: Code 2 (less than) gives 1 only when neither operand is a NaN and the operands are not equal under R1. The order comes from a signed compare of the patterns, inverted when both sign bits are set. Infinities take part in this order.
- R4: Code 3 (greater or equal) gives 1 exactly when neither operand is a NaN and code 2 would give 0.
- R5: Code 4 (minimum) returns a when a is not a NaN and either b is a NaN or a orders below b. Otherwise it returns b. In this order -0 lies below +0.
- R6: Code 5 (maximum) returns b when a is a NaN, or when b is not a NaN and a orders below b (-0 below +0). Otherwise it returns a.
- R7: Code 6 (saturate) returns 0x00000000 for a NaN or for any a with bit 31 set. It returns 0x3F800000 when a is above 0x3F800000 as an unsigned number. Otherwise it returns a unchanged.
- R8: Code 7 returns a with bit 31 cleared. Code 8 returns a with bit 31 inverted. Both apply to NaNs as well.
- R9: Code 9 (sign) returns 0x00000000 when bits 30..0 of a are all zero. Otherwise it returns 0x3F800000 with bit 31 copied from a.
- R10: A NaN is any pattern with bits 30..23 all ones and bits 22..0 nonzero. An all-ones exponent with a zero fraction is an infinity, not a NaN.
- R11: For codes 0 to 3 the value output is 0. For codes 4 to 9 the flag output is 0. For codes 10 to 15 both outputs are 0.
- R12: With the default register stage, outputs reflect the operands and code sampled at the previous rising clock edge. A synchronous active-low reset clears both outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand (single-precision pattern) |
| b_i | input | 32 | Second operand (single-precision pattern) |
| flag_o | output | 1 | Predicate result |
| value_o | output | 32 | Value result |

## Verification
The block holds no state apart from the output register. A wrong decision in the classify, order or select logic therefore shows up on the very next clock as a wrong flag or value for that operand pair. A corrupted register shows up the same way. The sharpest cases are signed zeros, infinities next to NaNs, and equal negative operands. In those cases a swapped comparator input or a missing sign inversion flips exactly one bit of the result. Every cycle is compared against a model that orders values by a signed magnitude key instead of by the raw encodings. All operand pairs drawn from a list of edge encodings are applied under every code.

// File: rtl/fpcm_pkg.sv
`timescale 1ns/1ps
// Shared format widths and operation codes for the compare/min-max unit.
// Assumes a binary interchange layout: sign, biased exponent, fraction.
package fpcm_pkg;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int DATA_W = 1 + EXP_W + MAN_W;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_EQ  = 4'd0,
        OP_NE  = 4'd1,
        OP_LT  = 4'd2,
        OP_GE  = 4'd3,
        OP_MIN = 4'd4,
        OP_MAX = 4'd5,
        OP_SAT = 4'd6,
        OP_ABS = 4'd7,
        OP_NEG = 4'd8,
        OP_SGN = 4'd9
    } fpcm_op_e;

    // Encoding of +1.0: exponent equal to the bias, fraction zero.
    localparam logic [DATA_W-1:0] ONE_PAT = {2'b00, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};
endpackage

// File: rtl/fpcm_classify.sv
`timescale 1ns/1ps
// Classifies one operand: NaN (max exponent, nonzero fraction) and zero of
// either sign. Purely combinational; the caller supplies the format widths.
module fpcm_classify #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int DATA_W = 1 + EXP_W + MAN_W
) (
    input  logic [DATA_W-1:0] x_i,
    output logic              nan_o,
    output logic              zero_o
);
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] frac_f;

    // Split the operand into exponent and fraction fields.
    always_comb begin
        exp_f  = x_i[DATA_W-2 -: EXP_W];
        frac_f = x_i[MAN_W-1:0];
    end

    // Flag NaN and zero magnitude.
    always_comb begin
        nan_o  = (&exp_f) && (|frac_f);
        zero_o = ~|x_i[DATA_W-2:0];
    end
endmodule

// File: rtl/fpcm_order.sv
`timescale 1ns/1ps
// Orders two non-NaN patterns with integer comparators only. The signed
// compare is inverted when both signs are set. The raw order puts -0 below
// +0; equality treats the two zeros as one value. NaNs are the caller's job.
module fpcm_order #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              a_zero_i,
    input  logic              b_zero_i,
    output logic              eq_o,
    output logic              below_o
);
    logic both_neg;
    logic s_lt;

    // Signed compare of the patterns and the both-negative correction.
    always_comb begin
        both_neg = a_i[DATA_W-1] & b_i[DATA_W-1];
        s_lt     = $signed(a_i) < $signed(b_i);
        below_o  = s_lt ^ both_neg;
    end

    // Equality: same pattern, or both operands are zeros.
    always_comb begin
        eq_o = (a_i == b_i) || (a_zero_i && b_zero_i);
    end
endmodule

// File: rtl/fpcm_select.sv
`timescale 1ns/1ps
// Forms the predicate and value results for the chosen operation. It
// assumes the NaN, zero, equality and order terms are already resolved.
// The output an operation does not use is driven to zero.
module fpcm_select
    import fpcm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              a_nan_i,
    input  logic              b_nan_i,
    input  logic              a_zero_i,
    input  logic              eq_i,
    input  logic              below_i,
    output logic              flag_o,
    output logic [DATA_W-1:0] value_o
);
    localparam logic [DATA_W-1:0] SIGN_M = {1'b1, {(DATA_W-1){1'b0}}};

    logic any_nan;
    logic num_lt;
    logic pick_a_min;
    logic pick_b_max;
    logic [DATA_W-1:0] sat_val;

    // Shared decision terms.
    always_comb begin
        any_nan    = a_nan_i | b_nan_i;
        num_lt     = !any_nan && !eq_i && below_i;
        pick_a_min = !a_nan_i && (b_nan_i || below_i);
        pick_b_max = a_nan_i || (!b_nan_i && below_i);
        if (a_nan_i || a_i[DATA_W-1])
            sat_val = '0;
        else if (a_i > ONE_PAT)
            sat_val = ONE_PAT;
        else
            sat_val = a_i;
    end

    // Drive the selected result; the unused output stays zero.
    always_comb begin
        flag_o  = 1'b0;
        value_o = '0;
        case (op_i)
            OP_EQ:  flag_o  = !any_nan && eq_i;
            OP_NE:  flag_o  = any_nan || !eq_i;
            OP_LT:  flag_o  = num_lt;
            OP_GE:  flag_o  = !any_nan && !num_lt;
            OP_MIN: value_o = pick_a_min ? a_i : b_i;
            OP_MAX: value_o = pick_b_max ? b_i : a_i;
            OP_SAT: value_o = sat_val;
            OP_ABS: value_o = a_i & ~SIGN_M;
            OP_NEG: value_o = a_i ^ SIGN_M;
            OP_SGN: value_o = a_zero_i ? '0 : (ONE_PAT | (a_i & SIGN_M));
            default: begin
                flag_o  = 1'b0;
                value_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/fpcm_unit.sv
`timescale 1ns/1ps
// Top of the compare / min-max / saturate unit. Classifies both operands,
// orders them, selects the result, and by default registers both outputs
// (synchronous active-low reset). OUT_REG = 0 gives a combinational path.
module fpcm_unit
    import fpcm_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              flag_o,
    output logic [DATA_W-1:0] value_o
);
    localparam int N_OPND = 2;

    logic [N_OPND-1:0][DATA_W-1:0] opnd;
    logic [N_OPND-1:0]             is_nan;
    logic [N_OPND-1:0]             is_zero;
    logic                          eq_w;
    logic                          below_w;
    logic                          flag_c;
    logic [DATA_W-1:0]             value_c;

    // Gather the operands so both are classified the same way.
    always_comb begin
        opnd[0] = a_i;
        opnd[1] = b_i;
    end

    for (genvar g = 0; g < N_OPND; g++) begin : g_cls
        fpcm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .x_i    (opnd[g]),
            .nan_o  (is_nan[g]),
            .zero_o (is_zero[g])
        );
    end

    fpcm_order #(.DATA_W(DATA_W)) u_ord (
        .a_i      (a_i),
        .b_i      (b_i),
        .a_zero_i (is_zero[0]),
        .b_zero_i (is_zero[1]),
        .eq_o     (eq_w),
        .below_o  (below_w)
    );

    fpcm_select #(.DATA_W(DATA_W)) u_sel (
        .op_i     (op_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .a_nan_i  (is_nan[0]),
        .b_nan_i  (is_nan[1]),
        .a_zero_i (is_zero[0]),
        .eq_i     (eq_w),
        .below_i  (below_w),
        .flag_o   (flag_c),
        .value_o  (value_c)
    );

    if (OUT_REG) begin : g_reg
        // Output register stage, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_o  <= 1'b0;
                value_o <= '0;
            end else begin
                flag_o  <= flag_c;
                value_o <= value_c;
            end
        end
    end else begin : g_comb
        // Direct combinational outputs.
        always_comb begin
            flag_o  = flag_c;
            value_o = value_c;
        end
    end
endmodule

// File: rtl/fpcm_checker.sv
`timescale 1ns/1ps
// Property checker for fpcm_unit. It keeps its own aligned copy of the
// inputs, delayed by one clock when the output stage is present.
module fpcm_checker
    import fpcm_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   op_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic              flag_o,
    input logic [DATA_W-1:0] value_o
);
    logic [OP_W-1:0]   op_s;
    logic [DATA_W-1:0] a_s;
    logic [DATA_W-1:0] b_s;
    logic              vld;
    logic              an_s;
    logic              bn_s;

    if (OUT_REG) begin : g_dly
        // Align the input copy with the registered outputs.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld  <= 1'b0;
                op_s <= '0;
                a_s  <= '0;
                b_s  <= '0;
            end else begin
                vld  <= 1'b1;
                op_s <= op_i;
                a_s  <= a_i;
                b_s  <= b_i;
            end
        end
    end else begin : g_now
        // Combinational outputs line up with the live inputs.
        always_comb begin
            vld  = 1'b1;
            op_s = op_i;
            a_s  = a_i;
            b_s  = b_i;
        end
    end

    // Independent NaN view of the aligned operands.
    always_comb begin
        an_s = (a_s[30:23] == 8'hFF) && (a_s[22:0] != 23'd0);
        bn_s = (b_s[30:23] == 8'hFF) && (b_s[22:0] != 23'd0);
    end

    p_flag_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && op_s >= 4'd4) |-> !flag_o)
        else $error("p_flag_idle_r11");

    p_value_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && (op_s <= 4'd3 || op_s >= 4'd10)) |-> (value_o == '0))
        else $error("p_value_idle_r11");

    p_eq_nan_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && op_s == 4'd0 && (an_s || bn_s)) |-> !flag_o)
        else $error("p_eq_nan_r1");

    p_ne_nan_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && op_s == 4'd1 && (an_s || bn_s)) |-> flag_o)
        else $error("p_ne_nan_r2");

    p_lt_nan_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && op_s == 4'd2 && (an_s || bn_s)) |-> !flag_o)
        else $error("p_lt_nan_r3");

    p_ge_nan_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && op_s == 4'd3 && (an_s || bn_s)) |-> !flag_o)
        else $error("p_ge_nan_r4");

    p_min_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && op_s == 4'd4) |-> (value_o == a_s || value_o == b_s))
        else $error("p_min_pick_r5");

    p_max_pick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && op_s == 4'd5) |-> (value_o == a_s || value_o == b_s))
        else $error("p_max_pick_r6");

    p_sat_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && op_s == 4'd6) |-> (value_o <= ONE_PAT))
        else $error("p_sat_bound_r7");

    p_neg_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && op_s == 4'd8) |-> ((value_o ^ a_s) == 32'h8000_0000))
        else $error("p_neg_flip_r8");

    p_sgn_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && op_s == 4'd9) |-> (value_o == '0 || value_o[30:0] == ONE_PAT[30:0]))
        else $error("p_sgn_shape_r9");
endmodule

bind fpcm_unit fpcm_checker #(.OUT_REG(OUT_REG)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .flag_o  (flag_o),
    .value_o (value_o)
);

// File: tb/fpcm_unit_test.sv
`timescale 1ns/1ps
module fpcm_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = 4'hF;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic        flag_o;
    logic [31:0] value_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    fpcm_unit uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .flag_o(flag_o), .value_o(value_o)
    );

    always #4 clk = ~clk;

    // ---- behavioural reference --------------------------------------
    function automatic bit m_nan(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    // Numeric key: both zeros map to 0.
    function automatic longint k_num(input logic [31:0] x);
        longint mag = longint'(x[30:0]);
        return x[31] ? -mag : mag;
    endfunction

    // Min/max key: -0 sits just below +0.
    function automatic longint k_mm(input logic [31:0] x);
        longint mag = longint'(x[30:0]);
        return x[31] ? -mag - 1 : mag;
    endfunction

    function automatic logic [32:0] model(input logic [3:0] op,
                                          input logic [31:0] a,
                                          input logic [31:0] b);
        bit nan = m_nan(a) || m_nan(b);
        bit eq  = !nan && (k_num(a) == k_num(b));
        bit lt  = !nan && (k_num(a) < k_num(b));
        logic [31:0] v = 0;
        bit f = 0;
        case (op)
            4'd0: f = eq;
            4'd1: f = !eq;
            4'd2: f = lt;
            4'd3: f = !nan && !lt;
            4'd4: v = (m_nan(a) ? b : m_nan(b) ? a : (k_mm(a) < k_mm(b)) ? a : b);
            4'd5: v = (m_nan(a) ? b : m_nan(b) ? a : (k_mm(a) < k_mm(b)) ? b : a);
            4'd6: v = (m_nan(a) || a[31]) ? 32'h0 : (a > 32'h3F800000 ? 32'h3F800000 : a);
            4'd7: v = {1'b0, a[30:0]};
            4'd8: v = {!a[31], a[30:0]};
            4'd9: v = (a[30:0] == 0) ? 32'h0 : {a[31], 31'h3F800000};
            default: ;
        endcase
        return {f, v};
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5: return "R6";
            4'd6: return "R7";
            4'd7, 4'd8: return "R8";
            4'd9: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one vector at a falling edge, compare one clock later.
    task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [32:0] e;
        string ft;
        string vt;
        op_i = op; a_i = a; b_i = b;
        e = model(op, a, b);
        @(negedge clk);
        ft = (op <= 4'd3) ? ((m_nan(a) || m_nan(b)) ? "R10" : tag_of(op)) : "R11";
        vt = (op >= 4'd4 && op <= 4'd9) ? tag_of(op) : "R11";
        check(ft, {31'd0, flag_o}, {31'd0, e[32]});
        check(vt, value_o, e[31:0]);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    logic [31:0] edge_v [14] = '{
        32'h00000000, 32'h80000000, 32'h3F800000, 32'hBF800000,
        32'h7F800000, 32'hFF800000, 32'h7FC00000, 32'h7F800001,
        32'hFFC00000, 32'h00000001, 32'h80000001, 32'h3F800001,
        32'h3F7FFFFF, 32'hC0000000
    };

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12", {31'd0, flag_o}, 32'd0);
        check("R12", value_o, 32'd0);
        // Inputs that would raise the flag must not pass while in reset.
        op_i = 4'd0; a_i = 32'd0; b_i = 32'd0;
        @(negedge clk);
        check("R12", {31'd0, flag_o}, 32'd0);
        rst_n = 1'b1;
        // R12: first vector after release appears one clock later.
        run(4'd0, 32'h80000000, 32'h00000000);
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 14; i++)
                for (int j = 0; j < 14; j++)
                    run(4'(op), edge_v[i], edge_v[j]);
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] ra = $urandom;
            logic [31:0] rb = (n % 4 == 0) ? {~ra[31], ra[30:0]} : $urandom;
            run(4'($urandom_range(0, 15)), ra, rb);
        end
        // R12: reset in mid-run clears the held result.
        run(4'd1, 32'h3F800000, 32'h40000000);
        rst_n = 1'b0;
        @(negedge clk);
        check("R12", {31'd0, flag_o}, 32'd0);
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end
endmodule